// File: doc/BRIEF.md
# Inter-Core Interrupt Doorbell Register Bank

This block is a small bank of word-addressed registers that lets any bus master knock on one of several processor cores. Each core has a doorbell register. Writing a one to its low bit sends a single-cycle interrupt pulse to that core. Writing ones to its upper 28 bits sets sticky source flags, so the receiving core can tell who rang. Software decides which flag stands for which sender.

Each core also has an acknowledge register, which shows the same flags. Writing ones to it clears the matching flags. A third register per core raises a non-maskable interrupt pulse. Reads come back through a registered read-data port. Every pulse comes from a two-state machine per output. PULSE_IDLE moves to PULSE_FIRE when a trigger is accepted (transition "fire"). PULSE_FIRE stays in PULSE_FIRE on a further trigger in the next cycle (transition "refire"). Otherwise it goes back to PULSE_IDLE (transition "expire").

Top module: `core_doorbell_regs`

## Requirements
- R1: After reset all source flags are 0, `irq_pulse` and `nmi_pulse` are 0, and `rsp_rdata` is 0.
- R2: Byte offsets, with the default of 4 cores: doorbell register of core c at 0x00+4c, acknowledge register at 0x10+4c, NMI register at 0x20+4c. Read data appears on `rsp_rdata` in the cycle after the read request is accepted. In any cycle that follows no read, `rsp_rdata` is 0.
- R3: A write with bit 0 = 1 to the doorbell register of core c drives `irq_pulse[c]` high for exactly the one cycle after the write. A write with bit 0 = 0 produces no pulse.
- R4: In a doorbell read, bit 0 and reserved bits 3:1 always return 0.
- R5: In a doorbell write, a 1 in any of bits 31:4 sets the matching source flag, and a 0 leaves it unchanged. Flags are returned in bits 31:4 of a doorbell read.
- R6: A read of the acknowledge register of core c returns the same value as a read of its doorbell register.
- R7: In an acknowledge write, a 1 in bits 31:4 clears the matching flag, and a 0 has no effect. An acknowledge write never produces a pulse, whatever its bit 0 holds.
- R8: A write with bit 0 = 1 to the NMI register of core c drives `nmi_pulse[c]` high for exactly one cycle after the write. The NMI register reads as 0, and its bits 31:1 change no flag.
- R9: A single doorbell write holding bit 0 = 1 and flag bits both sets the flags and produces the pulse.
- R10: An access at an offset at or above 0x30, or with byte-address bits 1:0 not 00, reads 0. A write there changes no flag and produces no pulse.
- R11: Doorbell writes in two consecutive cycles keep the pulse high for two consecutive cycles.
- R12: A write to one core's registers leaves the flags and pulses of every other core untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address of the access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, registered |
| irq_pulse | output | NUM_CORES (4) | Interrupt pulse per core |
| nmi_pulse | output | NUM_CORES (4) | Non-maskable interrupt pulse per core |

## Verification
The bench targets the cases where a wrong design would be caught:
- A doorbell write with bit 0 clear must not pulse. A design that treats any write as a trigger would fire there.
- Doorbell writes must only add flags, and acknowledge writes must only remove them. A design that stores the write data directly would wipe unrelated flags.
- A write with bit 0 set to an acknowledge register, a misaligned address or an address outside the map must not fire. A design with loose decoding would pulse or corrupt a neighbouring core.
- Back-to-back doorbell writes must give a two-cycle pulse. A pulse machine that always returns to idle would drop the second pulse.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
    typedef enum logic [1:0] {
        REGION_GEN,
        REGION_ACK,
        REGION_NMI,
        REGION_NONE
    } region_e;

    typedef enum logic {
        PULSE_IDLE,
        PULSE_FIRE
    } pulse_state_e;
endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
    import doorbell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]            addr_i,
    output region_e                      region_o,
    output logic [$clog2(NUM_CORES)-1:0] index_o
);
    localparam int IDX_W = $clog2(NUM_CORES);
    localparam int BLK_W = ADDR_W - IDX_W - 2;

    logic [BLK_W-1:0] block;

    assign block   = addr_i[ADDR_W-1:IDX_W+2];
    assign index_o = addr_i[IDX_W+1:2];

    always_comb begin
        region_o = REGION_NONE;
        if (addr_i[1:0] == 2'b00) begin
            if (block == BLK_W'(0))      region_o = REGION_GEN;
            else if (block == BLK_W'(1)) region_o = REGION_ACK;
            else if (block == BLK_W'(2)) region_o = REGION_NMI;
        end
    end
endmodule

// File: rtl/doorbell_flags.sv
module doorbell_flags #(
    parameter int FLAG_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] flags_q;

    // A set takes priority over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R5: every requested set bit is present on the next cycle
    assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R7: a clear with no concurrent set leaves those bits at 0
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i != '0) && (set_i == '0)) |=> ((flags_q & $past(clr_i)) == '0));

    // R12: no request means no change
    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/doorbell_pulse.sv
module doorbell_pulse
    import doorbell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    pulse_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PULSE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PULSE_IDLE: if (fire_i) state_d = PULSE_FIRE;        // fire
            PULSE_FIRE: state_d = fire_i ? PULSE_FIRE : PULSE_IDLE; // refire / expire
            default:    state_d = PULSE_IDLE;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == PULSE_FIRE);
    end

    // R3: an accepted trigger gives a pulse on the following cycle
    assert_fire_pulses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> pulse_o);

    // R3: without a trigger the pulse drops after one cycle
    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> !pulse_o);
endmodule

// File: rtl/core_doorbell_regs.sv
module core_doorbell_regs
    import doorbell_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int FLAG_LSB  = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [NUM_CORES-1:0] irq_pulse,
    output logic [NUM_CORES-1:0] nmi_pulse
);
    localparam int IDX_W  = $clog2(NUM_CORES);
    localparam int FLAG_W = DATA_W - FLAG_LSB;

    region_e           region;
    logic [IDX_W-1:0]  index;
    logic              wr_en;
    logic              rd_en;
    logic [FLAG_W-1:0] wr_flags;
    logic [FLAG_W-1:0] flags [NUM_CORES];
    logic [DATA_W-1:0] rd_value;

    doorbell_decode #(
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr_i   (req_addr),
        .region_o (region),
        .index_o  (index)
    );

    assign wr_en    = req_valid && req_write;
    assign rd_en    = req_valid && !req_write;
    assign wr_flags = req_wdata[DATA_W-1:FLAG_LSB];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic hit;
        logic gen_hit;
        logic ack_hit;
        logic nmi_hit;

        assign hit     = wr_en && (index == IDX_W'(c));
        assign gen_hit = hit && (region == REGION_GEN);
        assign ack_hit = hit && (region == REGION_ACK);
        assign nmi_hit = hit && (region == REGION_NMI);

        doorbell_flags #(
            .FLAG_W (FLAG_W)
        ) u_flags (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (gen_hit ? wr_flags : '0),
            .clr_i   (ack_hit ? wr_flags : '0),
            .flags_o (flags[c])
        );

        doorbell_pulse u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (gen_hit && req_wdata[0]),
            .pulse_o (irq_pulse[c])
        );

        doorbell_pulse u_nmi (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (nmi_hit && req_wdata[0]),
            .pulse_o (nmi_pulse[c])
        );
    end

    always_comb begin
        rd_value = '0;
        if ((region == REGION_GEN) || (region == REGION_ACK))
            rd_value = {flags[index], {FLAG_LSB{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rsp_rdata <= '0;
        else if (rd_en) rsp_rdata <= rd_value;
        else            rsp_rdata <= '0;
    end

    // R2: no read request, no read data next cycle
    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rsp_rdata == '0));

    // R4: trigger and reserved bits never read back as set
    assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[FLAG_LSB-1:0] == '0);

    // R10: a write outside the map raises no pulse
    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (region == REGION_NONE)) |=> ((irq_pulse == '0) && (nmi_pulse == '0)));

    // R12: one write per cycle can only pulse one output
    assert_single_target_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_pulse, nmi_pulse}));
endmodule

// File: tb/core_doorbell_regs_bench.sv
`timescale 1ns/1ps
module core_doorbell_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [3:0]  irq_pulse;
    logic [3:0]  nmi_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_doorbell_regs u_core_doorbell_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq_pulse (irq_pulse),
        .nmi_pulse (nmi_pulse)
    );

    function automatic logic [7:0] gen_a(int c); return 8'(c * 4);      endfunction
    function automatic logic [7:0] ack_a(int c); return 8'(16 + c * 4); endfunction
    function automatic logic [7:0] nmi_a(int c); return 8'(32 + c * 4); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the negedge where any pulse is visible.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq_pulse), 32'h0);
        chk("R1 nmi after reset", 32'(nmi_pulse), 32'h0);
        chk("R1 rdata after reset", rsp_rdata, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(gen_a(c), d);
            chk("R1 flags after reset", d, 32'h0);
        end
    endtask

    task automatic t_gen_pulse();
        logic [31:0] d;
        wr(gen_a(1), 32'h1);
        chk("R3 irq pulse core1", 32'(irq_pulse), 32'h2);
        chk("R3 no nmi on doorbell", 32'(nmi_pulse), 32'h0);
        @(negedge clk);
        chk("R3 pulse one cycle", 32'(irq_pulse), 32'h0);
        wr(gen_a(1), 32'hE);
        chk("R3 bit0 zero no pulse", 32'(irq_pulse), 32'h0);
        rd(gen_a(1), d);
        chk("R4 low bits read zero", d, 32'h0);
        @(negedge clk);
        chk("R2 rdata cleared after read", rsp_rdata, 32'h0);
    endtask

    task automatic t_flag_set();
        logic [31:0] d;
        wr(gen_a(2), 32'hA000_0010);
        chk("R5 no pulse without bit0", 32'(irq_pulse), 32'h0);
        rd(gen_a(2), d);
        chk("R5 flags set", d, 32'hA000_0010);
        wr(gen_a(2), 32'h0000_0100);
        rd(gen_a(2), d);
        chk("R5 zeros keep flags", d, 32'hA000_0110);
        rd(ack_a(2), d);
        chk("R6 ack view matches", d, 32'hA000_0110);
    endtask

    task automatic t_ack_clear();
        logic [31:0] d;
        wr(ack_a(2), 32'h8000_0011);
        chk("R7 ack write no pulse", 32'({irq_pulse, nmi_pulse}), 32'h0);
        rd(gen_a(2), d);
        chk("R7 ack clears ones", d, 32'h2000_0100);
        wr(ack_a(2), 32'h0);
        rd(ack_a(2), d);
        chk("R7 ack zeros no effect", d, 32'h2000_0100);
    endtask

    task automatic t_nmi();
        logic [31:0] d;
        wr(nmi_a(3), 32'hFFFF_FFFF);
        chk("R8 nmi pulse core3", 32'(nmi_pulse), 32'h8);
        chk("R8 no irq on nmi", 32'(irq_pulse), 32'h0);
        @(negedge clk);
        chk("R8 nmi one cycle", 32'(nmi_pulse), 32'h0);
        rd(nmi_a(3), d);
        chk("R8 nmi reads zero", d, 32'h0);
        rd(gen_a(3), d);
        chk("R8 nmi upper bits ignored", d, 32'h0);
    endtask

    task automatic t_combined();
        logic [31:0] d;
        wr(gen_a(0), 32'h00F0_0001);
        chk("R9 combined pulse", 32'(irq_pulse), 32'h1);
        rd(gen_a(0), d);
        chk("R9 combined flags", d, 32'h00F0_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_FFF1);
        chk("R10 above map no pulse", 32'({irq_pulse, nmi_pulse}), 32'h0);
        wr(8'h01, 32'hFFFF_FFF1);
        chk("R10 misaligned no pulse", 32'({irq_pulse, nmi_pulse}), 32'h0);
        wr(8'hFC, 32'hFFFF_FFF1);
        chk("R10 top offset no pulse", 32'({irq_pulse, nmi_pulse}), 32'h0);
        rd(gen_a(0), d);
        chk("R10 flags untouched", d, 32'h00F0_0000);
        rd(8'h30, d);
        chk("R10 unmapped read zero", d, 32'h0);
        rd(8'h11, d);
        chk("R10 misaligned read zero", d, 32'h0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = gen_a(3); req_wdata = 32'h1;
        @(negedge clk);
        chk("R11 first pulse", 32'(irq_pulse), 32'h8);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk("R11 second pulse", 32'(irq_pulse), 32'h8);
        @(negedge clk);
        chk("R11 pulse ends", 32'(irq_pulse), 32'h0);
    endtask

    task automatic t_independence();
        logic [31:0] d;
        wr(gen_a(1), 32'h0000_0011);
        chk("R12 only core1 pulses", 32'(irq_pulse), 32'h2);
        rd(gen_a(0), d);
        chk("R12 core0 flags kept", d, 32'h00F0_0000);
        rd(gen_a(2), d);
        chk("R12 core2 flags kept", d, 32'h2000_0100);
        rd(gen_a(3), d);
        chk("R12 core3 flags kept", d, 32'h0);
        rd(ack_a(1), d);
        chk("R12 core1 flags set", d, 32'h0000_0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gen_pulse();
        t_flag_set();
        t_ack_clear();
        t_nmi();
        t_combined();
        t_unmapped();
        t_back_to_back();
        t_independence();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule